// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the serial master on the two-wire PHY management bus. Software hands it one complete 32-bit management frame in a single register write. The frame holds the start pattern, the access type, the PHY and register addresses, the turnaround code and the 16-bit payload. The controller first sends a run of preamble ones. It then shifts the frame out most-significant bit first on a divided management clock. On a read it releases the data line and collects the PHY's reply into the low half of the same frame word. While a frame is on the wire, the idle flag is low.

The management clock is the system clock divided by 8, 16, 32 or 64, chosen with a 2-bit select. The select is captured when a frame starts. A port-enable input must be high for a frame to start, and dropping it halts the port at the next clock edge.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `frame_rdata` is 0.
- R2: A `frame_wr` pulse with `port_en` high while `idle` is 1 loads `frame_wdata` and drops `idle` from the next cycle. `idle` stays low for exactly 64 x D system cycles, where D is the selected divisor.
- R3: `div_sel` value s selects D = 8 << s (00 gives 8, 01 gives 16, 10 gives 32, 11 gives 64). In each bit period `mdc` is low for D/2 cycles and then high for D/2 cycles. `mdc` is held low whenever `idle` is 1.
- R4: The first 32 bit periods of every frame drive `mdio_o` = 1 with `mdio_oe` = 1.
- R5: Bit periods 32 to 63 drive frame-word bits 31 down to 0 in that order. The layout is [31:30] start (01), [29:28] operation (01 write, 10 read), [27:23] PHY address, [22:18] register address, [17:16] turnaround (10 on writes) and [15:0] data. Any operation other than 10 drives all 64 periods.
- R6: On a read (operation 10), `mdio_oe` is 0 for bit periods 46 to 63, which cover the turnaround and the data.
- R7: On a read, `mdio_i` is sampled at each rising `mdc` of bit periods 48 to 63, first sample into the most significant position. The 16 samples end up in `frame_rdata[15:0]`. `frame_rdata[31:16]` keeps the written value.
- R8: `mdio_o` and `mdio_oe` change only at bit-period boundaries, where `mdc` falls. They stay steady while `mdc` is high.
- R9: A `frame_wr` while `idle` is 0 is ignored. The frame word, the data returned and the frame length are unchanged.
- R10: With `port_en` low, `frame_wr` is ignored and leaves `frame_rdata` unchanged. If `port_en` is low at a clock edge during a frame, the frame stops at that edge, and after it `idle` is 1, `mdc` is 0 and `mdio_oe` is 0.
- R11: A change of `div_sel` during a frame has no effect on that frame's timing.
- R12: `mdio_oe` is 0 whenever `idle` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| port_en | input | 1 | Management port enable |
| div_sel | input | 2 | Management clock divisor select |
| frame_wr | input | 1 | Frame register write strobe |
| frame_wdata | input | 32 | Frame word to send |
| frame_rdata | output | 32 | Frame register contents, with read data after a read |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
`idle` falls one cycle after the write is accepted and rises 64 x D cycles later. `mdc` rises D/2 cycles into each bit period and falls at the end of it. Each read sample lands in `frame_rdata` one cycle after the rising-edge sample point. The bench keeps a behavioural model that advances on the same clock edges. It compares every output at the falling system-clock edge in each cycle, so each expected value is taken in the cycle it is due. Its PHY model changes `mdio_i` only on falling system-clock edges, well before the sample point.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int FRAME_W = 32;
   localparam int DATA_W  = 16;

   typedef enum logic [1:0] {
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10
   } mdio_op_e;

   typedef struct packed {
      logic [1:0]  start;
      logic [1:0]  op;
      logic [4:0]  phy_addr;
      logic [4:0]  reg_addr;
      logic [1:0]  ta;
      logic [15:0] data;
   } mdio_frame_t;

   function automatic int div_of_sel(input int log2_min, input int sel);
      return 1 << (log2_min + sel);
   endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
   parameter int DIV_SEL_W    = 2,
   parameter int DIV_LOG2_MIN = 3,
   localparam int CNT_W       = DIV_LOG2_MIN + (1 << DIV_SEL_W) - 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 run,
   input  logic [DIV_SEL_W-1:0] div_sel,
   output logic                 mdc,
   output logic                 rise_tick,
   output logic                 fall_tick
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term_q;
   logic [CNT_W-1:0] half_q;
   logic             mdc_q;

   always_comb begin
      rise_tick = run && (cnt_q == half_q);
      fall_tick = run && (cnt_q == term_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         term_q <= CNT_W'(mdio_pkg::div_of_sel(DIV_LOG2_MIN, 0) - 1);
         half_q <= CNT_W'(mdio_pkg::div_of_sel(DIV_LOG2_MIN, 0) / 2 - 1);
         mdc_q  <= 1'b0;
      end else if (start) begin
         cnt_q  <= '0;
         term_q <= CNT_W'(mdio_pkg::div_of_sel(DIV_LOG2_MIN, int'(div_sel)) - 1);
         half_q <= CNT_W'(mdio_pkg::div_of_sel(DIV_LOG2_MIN, int'(div_sel)) / 2 - 1);
         mdc_q  <= 1'b0;
      end else if (run) begin
         if (fall_tick) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            if (rise_tick) mdc_q <= 1'b1;
         end
      end else begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end
   end

   assign mdc = mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
   parameter int PRE_BITS = 32,
   localparam int FRAME_W = mdio_pkg::FRAME_W,
   localparam int TOTAL   = PRE_BITS + FRAME_W,
   localparam int BIT_W   = $clog2(TOTAL),
   localparam int FIDX_W  = $clog2(FRAME_W),
   localparam int TA_FIRST   = PRE_BITS + 14,
   localparam int DATA_FIRST = PRE_BITS + 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               port_en,
   input  logic               wr,
   input  logic [FRAME_W-1:0] wdata,
   input  logic               rise_tick,
   input  logic               fall_tick,
   input  logic               mdio_i,
   output logic               busy,
   output logic               start,
   output logic [FRAME_W-1:0] frame,
   output logic               mdio_o,
   output logic               mdio_oe
);
   import mdio_pkg::*;

   logic               busy_q;
   logic [BIT_W-1:0]   bit_q;
   logic [FRAME_W-1:0] frame_q;
   mdio_frame_t        fview;
   logic               is_read;
   logic               in_pre;
   logic               released;
   logic               capture;
   logic [FIDX_W-1:0]  fsel;

   always_comb begin
      fview    = frame_q;
      is_read  = (fview.op == OP_READ);
      in_pre   = (int'(bit_q) < PRE_BITS);
      released = is_read && (int'(bit_q) >= TA_FIRST);
      capture  = busy_q && port_en && rise_tick && is_read &&
                 (int'(bit_q) >= DATA_FIRST);
      start    = wr && port_en && !busy_q;
      fsel     = FIDX_W'(FRAME_W - 1 - (int'(bit_q) - PRE_BITS));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         bit_q   <= '0;
         frame_q <= '0;
      end else if (!port_en) begin
         busy_q <= 1'b0;
         bit_q  <= '0;
      end else if (start) begin
         busy_q  <= 1'b1;
         bit_q   <= '0;
         frame_q <= wdata;
      end else if (busy_q) begin
         if (capture)
            frame_q[DATA_W-1:0] <= {frame_q[DATA_W-2:0], mdio_i};
         if (fall_tick) begin
            if (int'(bit_q) == TOTAL - 1) begin
               busy_q <= 1'b0;
               bit_q  <= '0;
            end else begin
               bit_q <= bit_q + 1'b1;
            end
         end
      end
   end

   always_comb begin
      mdio_oe = busy_q && !released;
      if (!mdio_oe)   mdio_o = 1'b0;
      else if (in_pre) mdio_o = 1'b1;
      else            mdio_o = frame_q[fsel];
   end

   assign busy  = busy_q;
   assign frame = frame_q;
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
   parameter int PRE_BITS     = 32,
   parameter int DIV_SEL_W    = 2,
   parameter int DIV_LOG2_MIN = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 port_en,
   input  logic [DIV_SEL_W-1:0] div_sel,
   input  logic                 frame_wr,
   input  logic [31:0]          frame_wdata,
   output logic [31:0]          frame_rdata,
   output logic                 idle,
   output logic                 mdc,
   output logic                 mdio_o,
   output logic                 mdio_oe,
   input  logic                 mdio_i
);
   generate
      if (PRE_BITS < 1) begin : g_bad_pre
         $error("PRE_BITS must be at least 1");
      end
      if (DIV_LOG2_MIN < 1) begin : g_bad_div
         $error("DIV_LOG2_MIN must be at least 1");
      end
      if (DIV_SEL_W < 1) begin : g_bad_sel
         $error("DIV_SEL_W must be at least 1");
      end
   endgenerate

   logic busy;
   logic start;
   logic rise_tick;
   logic fall_tick;

   mdio_clk_gen #(
      .DIV_SEL_W   (DIV_SEL_W),
      .DIV_LOG2_MIN(DIV_LOG2_MIN)
   ) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .run      (busy && port_en),
      .div_sel  (div_sel),
      .mdc      (mdc),
      .rise_tick(rise_tick),
      .fall_tick(fall_tick)
   );

   mdio_frame_seq #(
      .PRE_BITS(PRE_BITS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .port_en  (port_en),
      .wr       (frame_wr),
      .wdata    (frame_wdata),
      .rise_tick(rise_tick),
      .fall_tick(fall_tick),
      .mdio_i   (mdio_i),
      .busy     (busy),
      .start    (start),
      .frame    (frame_rdata),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe)
   );

   assign idle = !busy;
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        port_en,
   input logic        frame_wr,
   input logic [31:0] frame_rdata,
   input logic        idle,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe
);
   a_r12_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !mdio_oe);

   a_r3_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !mdc);

   a_r8_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

   a_r2_write_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && frame_wr && port_en) |=> !idle);

   a_r10_disable_halts: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> (idle && !mdc && !mdio_oe));

   a_r10_disabled_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !port_en) |=> $stable(frame_rdata));

   a_r9_header_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> $stable(frame_rdata[31:16]));
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .port_en    (port_en),
   .frame_wr   (frame_wr),
   .frame_rdata(frame_rdata),
   .idle       (idle),
   .mdc        (mdc),
   .mdio_o     (mdio_o),
   .mdio_oe    (mdio_oe)
);

// File: tb/mdio_frame_ctrl_test.sv
module mdio_frame_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        port_en = 1'b1;
   logic [1:0]  div_sel = 2'b00;
   logic        frame_wr = 1'b0;
   logic [31:0] frame_wdata = '0;
   logic [31:0] frame_rdata;
   logic        idle;
   logic        mdc;
   logic        mdio_o;
   logic        mdio_oe;
   logic        mdio_i = 1'b1;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   // behavioural reference state
   bit          m_busy = 0;
   bit          m_read = 0;
   int          m_t = 0;
   int          m_div = 8;
   logic [31:0] m_frame = '0;
   logic [15:0] phy_val = '0;
   bit          live = 0;

   // pin capture of driven bits
   logic [63:0] cap = '0;
   int          nbits = 0;
   logic        prev_mdc = 1'b0;

   mdio_frame_ctrl uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .port_en    (port_en),
      .div_sel    (div_sel),
      .frame_wr   (frame_wr),
      .frame_wdata(frame_wdata),
      .frame_rdata(frame_rdata),
      .idle       (idle),
      .mdc        (mdc),
      .mdio_o     (mdio_o),
      .mdio_oe    (mdio_oe),
      .mdio_i     (mdio_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // model advances on the same edges as the design
   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_busy = 0; m_t = 0; m_frame = '0;
      end else if (m_busy && !port_en) begin
         m_busy = 0;
      end else if (m_busy) begin
         if (m_read && (m_t % m_div) == m_div/2 - 1 && (m_t / m_div) >= 48)
            m_frame[15:0] = {m_frame[14:0], mdio_i};
         m_t++;
         if (m_t == 64 * m_div) m_busy = 0;
      end else if (frame_wr && port_en) begin
         m_busy  = 1;
         m_t     = 0;
         m_frame = frame_wdata;
         m_read  = (frame_wdata[29:28] == 2'b10);
         m_div   = 8 << div_sel;
      end
      if (cycles > WATCHDOG) begin
         fails++; checks++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   // per-cycle comparison, PHY reply and pin capture
   always @(negedge clk) begin
      int  b;
      bit  e_mdc, e_oe, e_o, ok;
      b     = m_t / m_div;
      e_mdc = m_busy && ((m_t % m_div) >= m_div / 2);
      e_oe  = m_busy && !(m_read && b >= 46);
      e_o   = (b < 32) ? 1'b1 : m_frame[31 - (b - 32)];
      if (live) begin
         ok = (idle == !m_busy) && (mdc == e_mdc) && (mdio_oe == e_oe) &&
              (!e_oe || mdio_o == e_o) && (frame_rdata == m_frame);
         checks++;
         if (!ok) begin
            fails++;
            if (idle != !m_busy)
               $display("FAIL R2 idle actual=%0b expected=%0b t=%0d", idle, !m_busy, m_t);
            if (mdc != e_mdc)
               $display("FAIL R3 mdc actual=%0b expected=%0b t=%0d", mdc, e_mdc, m_t);
            if (mdio_oe != e_oe)
               $display("FAIL R6 mdio_oe actual=%0b expected=%0b t=%0d", mdio_oe, e_oe, m_t);
            if (e_oe && mdio_o != e_o)
               $display("FAIL R5 mdio_o actual=%0b expected=%0b t=%0d", mdio_o, e_o, m_t);
            if (frame_rdata != m_frame)
               $display("FAIL R7 frame_rdata actual=%0h expected=%0h", frame_rdata, m_frame);
         end
         if (mdc && !prev_mdc && mdio_oe) begin
            cap = {cap[62:0], mdio_o};
            nbits++;
         end
      end
      prev_mdc = mdc;
      mdio_i = (m_busy && m_read && b >= 48) ? phy_val[15 - (b - 48)] : 1'b1;
   end

   // run one frame; disturb=1 changes div_sel and writes again mid-frame (R9, R11)
   task automatic run_frame(input logic [31:0] w, input logic [1:0] sel,
                            input bit disturb, input string tag);
      int dur;
      int expn;
      logic [63:0] mask, expcap;
      div_sel = sel;
      cap = '0; nbits = 0;
      @(negedge clk);
      frame_wr = 1'b1; frame_wdata = w;
      @(negedge clk);
      frame_wr = 1'b0;
      dur = 0;
      while (!idle && dur < 20000) begin
         dur++;
         if (disturb && dur == 100) begin
            div_sel = 2'b00; frame_wr = 1'b1; frame_wdata = 32'h5AA5_0F0F;
         end else begin
            frame_wr = 1'b0;
         end
         @(negedge clk);
      end
      frame_wr = 1'b0;
      chk(dur == 64 * (8 << sel), {tag, " R2/R11 busy length"}, dur, 64 * (8 << sel));
      expn = (w[29:28] == 2'b10) ? 46 : 64;
      chk(nbits == expn, {tag, " R6 driven bit count"}, nbits, expn);
      mask   = (expn == 64) ? '1 : ((64'd1 << expn) - 1);
      expcap = {32'hFFFF_FFFF, w} >> (64 - expn);
      chk((cap & mask) == expcap, {tag, " R4/R5 bits on wire"}, cap & mask, expcap);
   endtask

   initial begin
      logic [31:0] w;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      live = 1;
      chk(idle == 1'b1, "R1 idle after reset", idle, 1);
      chk(mdc == 1'b0, "R1 mdc after reset", mdc, 0);
      chk(mdio_oe == 1'b0, "R1 mdio_oe after reset", mdio_oe, 0);
      chk(frame_rdata == 32'h0, "R1 frame_rdata after reset", frame_rdata, 0);

      // write, divisor 8
      w = {2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'hBEEF};
      run_frame(w, 2'b00, 0, "wr/8");
      chk(frame_rdata == w, "R5 write frame kept", frame_rdata, w);

      // read, divisor 16
      phy_val = 16'hA5C3;
      w = {2'b01, 2'b10, 5'h11, 5'h01, 2'b10, 16'h0000};
      run_frame(w, 2'b01, 0, "rd/16");
      chk(frame_rdata == {w[31:16], 16'hA5C3}, "R7 read data", frame_rdata, {w[31:16], 16'hA5C3});

      // read, divisor 32, disturbed by div_sel change and a busy write
      phy_val = 16'h3C5A;
      w = {2'b01, 2'b10, 5'h1F, 5'h1E, 2'b10, 16'hFFFF};
      run_frame(w, 2'b10, 1, "rd/32");
      chk(frame_rdata == {w[31:16], 16'h3C5A}, "R9 busy write ignored", frame_rdata, {w[31:16], 16'h3C5A});

      // write, divisor 64
      w = {2'b01, 2'b01, 5'h00, 5'h1F, 2'b10, 16'h1234};
      run_frame(w, 2'b11, 0, "wr/64");
      chk(frame_rdata == w, "R3 div64 frame kept", frame_rdata, w);

      // port disabled: write ignored
      port_en = 1'b0;
      @(negedge clk);
      frame_wr = 1'b1; frame_wdata = 32'h6000_0000;
      @(negedge clk);
      frame_wr = 1'b0;
      repeat (3) @(negedge clk);
      chk(idle == 1'b1, "R10 disabled write no start", idle, 1);
      chk(frame_rdata == w, "R10 disabled write no load", frame_rdata, w);

      // abort mid-frame
      port_en = 1'b1;
      w = {2'b01, 2'b10, 5'h05, 5'h06, 2'b10, 16'h0000};
      div_sel = 2'b00;
      @(negedge clk);
      frame_wr = 1'b1; frame_wdata = w;
      @(negedge clk);
      frame_wr = 1'b0;
      repeat (40) @(negedge clk);
      chk(idle == 1'b0, "R10 running before abort", idle, 0);
      port_en = 1'b0;
      @(negedge clk);
      chk(idle == 1'b1, "R10 abort idle", idle, 1);
      chk(mdc == 1'b0, "R10 abort mdc", mdc, 0);
      chk(mdio_oe == 1'b0, "R12 abort no drive", mdio_oe, 0);
      port_en = 1'b1;
      repeat (3) @(negedge clk);

      // another write pattern after recovery
      w = {2'b01, 2'b01, 5'h15, 5'h0A, 2'b10, 16'h8001};
      run_frame(w, 2'b00, 0, "wr/8b");
      chk(idle == 1'b1 && mdio_oe == 1'b0, "R12 idle no drive", mdio_oe, 0);

      repeat (5) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule